// File: doc/BRIEF.md
# Flash Program/Erase Status Bit Generator

This block sits on the read-data path of a NOR-style flash device. While the internal algorithm is programming or erasing, it replaces array data with a status word. A host polls that word through ordinary read cycles and uses it to tell three things apart:
- whether the operation is still running;
- whether an erase is suspended, and which sectors take part in it;
- whether the operation failed by running past its internal pulse budget.

When the device is idle, the block returns the array data unchanged.

A command decoder outside the block reports each accepted command as a one-cycle `op_start` pulse with a kind code. It also drives a `busy` level while the embedded algorithm works. The block keeps its own record of the device view: array read, programming, erasing, erase suspended, or programming inside a suspend. It also keeps a latched failure flag, so the status bits follow the command history without any help from outside.

A read cycle is qualified when chip enable and output enable are both active. The two toggle bits are advanced when a qualified read ends, so two reads in a row can be compared. The status word is registered and is refreshed on every clock.

Top module: `flash_status_gen`

## Requirements
- R1: On reset the view is array read and the latched failure flag is clear. From the second clock after reset is released, `dq_out` equals `arr_data`.
- R2: In array-read view, every read returns `arr_data`, and reads do not advance either toggle bit.
- R3: While a program runs (kind 0), bit 6 of consecutive reads alternates. Bit 2 stays constant, and bits 3 and 5 read 0.
- R4: When `busy` falls without a failure, program and erase return to array read. Reads then return `arr_data` and nothing toggles.
- R5: During an active erase, bit 6 alternates on every read. Bit 2 alternates only on reads of a sector whose bit is set in `sect_sel`, and holds its value on reads of any other sector.
- R6: During an erase suspend (kind 3 while erasing), reads of a selected sector return status with bit 6 constant and bit 2 alternating. Reads of an unselected sector return `arr_data`.
- R7: During a sector erase (kind 1), bit 3 reads 0 while `etimer_run` is high and 1 once it is low. During a chip erase (kind 2), bit 3 reads 1 whatever the value of `etimer_run`.
- R8: Bit 5 reads 0 while the operation is within its limit. When `limit_hit` is seen during a running operation, bit 5 latches to 1 and stays at 1 after `limit_hit` and `busy` fall. Bit 6 keeps alternating while the failure is held.
- R9: A reset command while a failure is held clears bit 5. After a failed program (kind 0) or erase, the view returns to array read. After a failed program inside a suspend (kind 5), the view returns to erase-suspend read.
- R10: A reset command given while no failure is held has no effect on a running operation.
- R11: While a failure is held, starting a new program or erase clears bit 5 and enters the new operation.
- R12: Resume (kind 4) takes a suspended erase back to active erase. A program inside a suspend (kind 5) toggles bit 6, and when `busy` falls it returns to erase-suspend read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_act | input | 1 | Chip enable active |
| oe_act | input | 1 | Output enable active |
| rd_sector | input | SECT_W | Sector of the read address |
| busy | input | 1 | Embedded algorithm running |
| op_start | input | 1 | One-cycle accepted-command pulse |
| op_kind | input | 3 | Command kind: 0 program, 1 sector erase, 2 chip erase, 3 suspend, 4 resume, 5 program in suspend |
| sect_sel | input | NUM_SECT | Sectors selected for erase, one bit per sector |
| limit_hit | input | 1 | Internal pulse-count limit exceeded |
| etimer_run | input | 1 | Sector-erase accept window still open |
| reset_cmd | input | 1 | One-cycle reset command pulse |
| arr_data | input | DATA_W | Array read data |
| dq_out | output | DATA_W | Registered read data or status word |

## Verification
A command pulse changes the view on the next clock edge, and that view reaches `dq_out` one edge later. The bench therefore waits two clocks after any pulse or level change before it samples.

During a read, `dq_out` is sampled two clocks after the strobe is raised. The end of a read advances the toggle bits at the first edge after the strobe falls, and the bench lets two clocks pass before the next read starts.

Toggle behaviour is checked by comparing pairs of consecutive reads, never against an absolute phase. All sampling takes place on the falling clock edge.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

  typedef enum logic [2:0] {
    V_ARRAY = 3'd0,
    V_PROG  = 3'd1,
    V_ERASE = 3'd2,
    V_SUSP  = 3'd3,
    V_SPROG = 3'd4
  } view_e;

  typedef enum logic [2:0] {
    K_PROG       = 3'd0,
    K_SECT_ERASE = 3'd1,
    K_CHIP_ERASE = 3'd2,
    K_SUSPEND    = 3'd3,
    K_RESUME     = 3'd4,
    K_SUSP_PROG  = 3'd5
  } kind_e;

  // Status word bit positions, as decoded by host polling software.
  localparam int unsigned BIT_TGL = 6;  // running / suspend toggle
  localparam int unsigned BIT_TMO = 5;  // pulse limit exceeded
  localparam int unsigned BIT_ETM = 3;  // erase has begun
  localparam int unsigned BIT_SEL = 2;  // selected-sector toggle

  function automatic logic is_running(view_e v);
    return (v == V_PROG) || (v == V_ERASE) || (v == V_SPROG);
  endfunction

  function automatic logic is_new_op(kind_e k);
    return (k == K_PROG) || (k == K_SECT_ERASE) || (k == K_CHIP_ERASE);
  endfunction

endpackage

// File: rtl/flash_stat_mode.sv
module flash_stat_mode
  import flash_stat_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       op_start,
  input  logic [2:0] op_kind,
  input  logic       busy,
  input  logic       limit_hit,
  input  logic       reset_cmd,
  output view_e      view,
  output logic       fail,
  output logic       chip
);

  kind_e kind;
  view_e view_n;
  logic  fail_n;
  logic  chip_n;

  assign kind = kind_e'(op_kind);

  always_comb begin
    view_n = view;
    fail_n = fail;
    chip_n = chip;
    if (fail) begin
      // Held failure: only a reset command or a fresh operation leaves it.
      if (reset_cmd) begin
        fail_n = 1'b0;
        view_n = (view == V_SPROG) ? V_SUSP : V_ARRAY;
      end else if (op_start && is_new_op(kind)) begin
        fail_n = 1'b0;
        view_n = (kind == K_PROG) ? V_PROG : V_ERASE;
        chip_n = (kind == K_CHIP_ERASE);
      end
    end else begin
      unique case (view)
        V_ARRAY: begin
          if (op_start && is_new_op(kind)) begin
            view_n = (kind == K_PROG) ? V_PROG : V_ERASE;
            chip_n = (kind == K_CHIP_ERASE);
          end
        end
        V_PROG: begin
          if (limit_hit)  fail_n = 1'b1;
          else if (!busy) view_n = V_ARRAY;
        end
        V_ERASE: begin
          if (limit_hit)                            fail_n = 1'b1;
          else if (op_start && kind == K_SUSPEND)   view_n = V_SUSP;
          else if (!busy)                           view_n = V_ARRAY;
        end
        V_SUSP: begin
          if (op_start && kind == K_RESUME)         view_n = V_ERASE;
          else if (op_start && kind == K_SUSP_PROG) view_n = V_SPROG;
        end
        V_SPROG: begin
          if (limit_hit)  fail_n = 1'b1;
          else if (!busy) view_n = V_SUSP;
        end
        default: view_n = V_ARRAY;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      view <= V_ARRAY;
      fail <= 1'b0;
      chip <= 1'b0;
    end else begin
      view <= view_n;
      fail <= fail_n;
      chip <= chip_n;
    end
  end

endmodule

// File: rtl/flash_stat_toggle.sv
module flash_stat_toggle
  import flash_stat_pkg::*;
#(
  parameter int unsigned NUM_SECT = 16,
  parameter int unsigned SECT_W   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ce_act,
  input  logic                oe_act,
  input  logic [SECT_W-1:0]   rd_sector,
  input  view_e               view,
  input  logic [NUM_SECT-1:0] sect_sel,
  output logic                rd_fall,
  output logic                t6,
  output logic                t2
);

  logic              rd_act;
  logic              rd_q;
  logic [SECT_W-1:0] sec_q;
  logic              sel_hit;
  logic              adv6;
  logic              adv2;

  assign rd_act  = ce_act & oe_act;
  assign rd_fall = rd_q & ~rd_act;
  assign sel_hit = sect_sel[sec_q];
  assign adv6    = rd_fall & is_running(view);
  assign adv2    = rd_fall & sel_hit & ((view == V_ERASE) || (view == V_SUSP));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= 1'b0;
      sec_q <= '0;
      t6    <= 1'b0;
      t2    <= 1'b0;
    end else begin
      rd_q <= rd_act;
      if (rd_act) sec_q <= rd_sector;
      if (adv6)   t6 <= ~t6;
      if (adv2)   t2 <= ~t2;
    end
  end

endmodule

// File: rtl/flash_stat_mux.sv
module flash_stat_mux
  import flash_stat_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_SECT = 16,
  parameter int unsigned SECT_W   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  view_e               view,
  input  logic                fail,
  input  logic                chip,
  input  logic                etimer_run,
  input  logic                t6,
  input  logic                t2,
  input  logic [SECT_W-1:0]   rd_sector,
  input  logic [NUM_SECT-1:0] sect_sel,
  input  logic [DATA_W-1:0]   arr_data,
  output logic [DATA_W-1:0]   dq_q
);

  logic [DATA_W-1:0] stat;
  logic              begun;
  logic              show;

  assign begun = (view == V_ERASE) & (chip | ~etimer_run);
  assign show  = is_running(view) | ((view == V_SUSP) & sect_sel[rd_sector]);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == BIT_TGL) begin : g_tgl
      assign stat[i] = t6;
    end else if (i == BIT_TMO) begin : g_tmo
      assign stat[i] = fail;
    end else if (i == BIT_ETM) begin : g_etm
      assign stat[i] = begun;
    end else if (i == BIT_SEL) begin : g_sel
      assign stat[i] = t2;
    end else begin : g_zero
      assign stat[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dq_q <= '0;
    else     dq_q <= show ? stat : arr_data;
  end

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_stat_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_SECT = 16,
  localparam int unsigned SECT_W  = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ce_act,
  input  logic                oe_act,
  input  logic [SECT_W-1:0]   rd_sector,
  input  logic                busy,
  input  logic                op_start,
  input  logic [2:0]          op_kind,
  input  logic [NUM_SECT-1:0] sect_sel,
  input  logic                limit_hit,
  input  logic                etimer_run,
  input  logic                reset_cmd,
  input  logic [DATA_W-1:0]   arr_data,
  output logic [DATA_W-1:0]   dq_out
);

  view_e view_w;
  logic  fail_w;
  logic  chip_w;
  logic  rd_fall_w;
  logic  t6_w;
  logic  t2_w;

  flash_stat_mode u_mode (
    .clk       (clk),
    .rst       (rst),
    .op_start  (op_start),
    .op_kind   (op_kind),
    .busy      (busy),
    .limit_hit (limit_hit),
    .reset_cmd (reset_cmd),
    .view      (view_w),
    .fail      (fail_w),
    .chip      (chip_w)
  );

  flash_stat_toggle #(.NUM_SECT(NUM_SECT), .SECT_W(SECT_W)) u_tgl (
    .clk       (clk),
    .rst       (rst),
    .ce_act    (ce_act),
    .oe_act    (oe_act),
    .rd_sector (rd_sector),
    .view      (view_w),
    .sect_sel  (sect_sel),
    .rd_fall   (rd_fall_w),
    .t6        (t6_w),
    .t2        (t2_w)
  );

  flash_stat_mux #(.DATA_W(DATA_W), .NUM_SECT(NUM_SECT), .SECT_W(SECT_W)) u_mux (
    .clk        (clk),
    .rst        (rst),
    .view       (view_w),
    .fail       (fail_w),
    .chip       (chip_w),
    .etimer_run (etimer_run),
    .t6         (t6_w),
    .t2         (t2_w),
    .rd_sector  (rd_sector),
    .sect_sel   (sect_sel),
    .arr_data   (arr_data),
    .dq_q       (dq_out)
  );

endmodule

// File: rtl/flash_status_gen_chk.sv
module flash_status_gen_chk
  import flash_stat_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              op_start,
  input logic              reset_cmd,
  input logic              busy,
  input logic              rd_fall,
  input view_e             view,
  input logic              fail,
  input logic              t6,
  input logic [DATA_W-1:0] dq_out
);

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (view == V_ARRAY && !fail));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (view == V_ARRAY) |=> $stable(t6));

  p_run_toggle_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_fall && is_running(view)) |=> (t6 != $past(t6)));

  p_susp_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (view == V_SUSP) |=> $stable(t6));

  p_fail_latch_r8: assert property (@(posedge clk) disable iff (rst)
    (fail && !reset_cmd && !op_start) |=> fail);

  p_fail_shown_r8: assert property (@(posedge clk) disable iff (rst)
    (fail && is_running(view)) |=> dq_out[BIT_TMO]);

  p_reset_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (!fail && reset_cmd && view == V_PROG && busy && !op_start) |=> (view == V_PROG));

endmodule

bind flash_status_gen flash_status_gen_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_start  (op_start),
  .reset_cmd (reset_cmd),
  .busy      (busy),
  .rd_fall   (rd_fall_w),
  .view      (view_w),
  .fail      (fail_w),
  .t6        (t6_w),
  .dq_out    (dq_out)
);

// File: tb/flash_status_gen_tb.sv
`timescale 1ns/1ps
module flash_status_gen_tb;

  localparam int DW = 8;
  localparam int NS = 16;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce_act = 0, oe_act = 0;
  logic [SW-1:0] rd_sector = '0;
  logic          busy = 0, op_start = 0;
  logic [2:0]    op_kind = '0;
  logic [NS-1:0] sect_sel = '0;
  logic          limit_hit = 0, etimer_run = 0, reset_cmd = 0;
  logic [DW-1:0] arr_data = 8'hA5;
  logic [DW-1:0] dq_out;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  flash_status_gen #(.DATA_W(DW), .NUM_SECT(NS)) u_dut (
    .clk(clk), .rst(rst), .ce_act(ce_act), .oe_act(oe_act),
    .rd_sector(rd_sector), .busy(busy), .op_start(op_start),
    .op_kind(op_kind), .sect_sel(sect_sel), .limit_hit(limit_hit),
    .etimer_run(etimer_run), .reset_cmd(reset_cmd), .arr_data(arr_data),
    .dq_out(dq_out)
  );

  task automatic chk(input logic ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_read(input logic [SW-1:0] s, output logic [DW-1:0] d);
    @(negedge clk);
    ce_act = 1; oe_act = 1; rd_sector = s;
    wait_clk(2);
    d = dq_out;
    ce_act = 0; oe_act = 0;
    wait_clk(2);
  endtask

  task automatic pulse_op(input logic [2:0] k, input logic bsy);
    @(negedge clk);
    op_start = 1; op_kind = k; busy = bsy;
    @(negedge clk);
    op_start = 0;
    wait_clk(2);
  endtask

  task automatic pulse_rst_cmd();
    @(negedge clk); reset_cmd = 1;
    @(negedge clk); reset_cmd = 0;
    wait_clk(2);
  endtask

  task automatic raise_fail();
    @(negedge clk); limit_hit = 1;
    @(negedge clk); limit_hit = 0; busy = 0;
    wait_clk(2);
  endtask

  task automatic t_reset();
    rst = 1; wait_clk(3); rst = 0; wait_clk(2);
    chk(dq_out == arr_data, "R1 reset shows array", dq_out, arr_data);
  endtask

  task automatic t_idle();
    logic [DW-1:0] a, b;
    do_read(4'd2, a);
    arr_data = 8'h3C;
    do_read(4'd2, b);
    chk(a == 8'hA5, "R2 idle read 1", a, 8'hA5);
    chk(b == 8'h3C, "R2 idle read 2", b, 8'h3C);
  endtask

  task automatic t_program();
    logic [DW-1:0] a, b, c;
    pulse_op(3'd0, 1'b1);
    do_read(4'd1, a); do_read(4'd1, b); do_read(4'd1, c);
    chk(a[6] != b[6] && b[6] != c[6], "R3 bit6 alternates", b, a ^ 8'h40);
    chk(a[2] == b[2] && b[2] == c[2], "R3 bit2 steady", b, a);
    chk(a[3] == 0 && a[5] == 0, "R3/R8 bits3,5 zero", a, a & 8'hD7);
    pulse_rst_cmd();
    do_read(4'd1, a); do_read(4'd1, b);
    chk(a[6] != b[6], "R10 reset ignored while running", b, a ^ 8'h40);
    busy = 0; wait_clk(2);
    do_read(4'd1, a); do_read(4'd1, b);
    chk(a == arr_data && b == arr_data, "R4 program done -> array", a, arr_data);
  endtask

  task automatic t_erase();
    logic [DW-1:0] a, b;
    sect_sel = 16'h0010; etimer_run = 1;
    pulse_op(3'd1, 1'b1);
    do_read(4'd4, a);
    chk(a[3] == 1'b0, "R7 bit3 low while timer runs", a, a & 8'hF7);
    etimer_run = 0; wait_clk(2);
    do_read(4'd4, a); do_read(4'd4, b);
    chk(b[3] == 1'b1, "R7 bit3 high after timer", b, b | 8'h08);
    chk(a[6] != b[6] && a[2] != b[2], "R5 selected: bit6 and bit2 toggle", b, a ^ 8'h44);
    do_read(4'd1, a); do_read(4'd1, b);
    chk(a[6] != b[6] && a[2] == b[2], "R5 unselected: bit2 holds", b, a ^ 8'h40);
    // suspend
    @(negedge clk); op_start = 1; op_kind = 3'd3;
    @(negedge clk); op_start = 0; busy = 0; wait_clk(2);
    do_read(4'd4, a); do_read(4'd4, b);
    chk(a[6] == b[6] && a[2] != b[2], "R6 suspended selected", b, a ^ 8'h04);
    do_read(4'd1, a);
    chk(a == arr_data, "R6 suspended unselected array", a, arr_data);
    // program inside suspend, then fail
    pulse_op(3'd5, 1'b1);
    do_read(4'd1, a); do_read(4'd1, b);
    chk(a[6] != b[6], "R12 suspend-program toggles", b, a ^ 8'h40);
    raise_fail();
    do_read(4'd1, a); do_read(4'd1, b);
    chk(a[5] && b[5], "R8 bit5 latched", b, b | 8'h20);
    chk(a[6] != b[6], "R8 bit6 toggles while failed", b, a ^ 8'h40);
    pulse_rst_cmd();
    do_read(4'd4, a); do_read(4'd4, b);
    chk(a[5] == 0 && a[6] == b[6] && a[2] != b[2], "R9 reset -> suspend read", b, a ^ 8'h04);
    do_read(4'd1, a);
    chk(a == arr_data, "R9 suspend read unselected", a, arr_data);
    pulse_op(3'd4, 1'b1);
    do_read(4'd1, a); do_read(4'd1, b);
    chk(a[6] != b[6], "R12 resume toggles", b, a ^ 8'h40);
    busy = 0; wait_clk(2);
    do_read(4'd1, a);
    chk(a == arr_data, "R4 erase done -> array", a, arr_data);
  endtask

  task automatic t_chip();
    logic [DW-1:0] a;
    etimer_run = 1;
    pulse_op(3'd2, 1'b1);
    do_read(4'd7, a);
    chk(a[3] == 1'b1, "R7 chip erase bit3 high", a, a | 8'h08);
    etimer_run = 0;
    raise_fail();
    do_read(4'd7, a);
    chk(a[5] == 1'b1, "R8 chip erase fail", a, a | 8'h20);
    pulse_rst_cmd();
    do_read(4'd7, a);
    chk(a == arr_data, "R9 reset -> array", a, arr_data);
  endtask

  task automatic t_newop();
    logic [DW-1:0] a;
    pulse_op(3'd0, 1'b1);
    raise_fail();
    pulse_op(3'd0, 1'b1);
    do_read(4'd0, a);
    chk(a[5] == 1'b0, "R11 new op clears bit5", a, a & 8'hDF);
    busy = 0; wait_clk(2);
    do_read(4'd0, a);
    chk(a == arr_data, "R11 new op completes", a, arr_data);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_program();
    t_erase();
    t_chip();
    t_newop();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule